// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the processor-facing side of a classic 16550-style serial port. Software reaches eight byte-wide registers through a 3-bit offset with separate read and write strobes. Received bytes arrive on a byte-stream input and wait in a small queue until software reads them. Bytes that software writes to the data port leave on a byte-stream output. Bit timing, baud generation, framing and modem pins belong to other blocks.

Two receive/transmit events are tracked as pending interrupt sources: a character-timeout source and a transmit-holding-empty source. They are ranked by a fixed priority into an identification code that software reads at offset 2, and that read can have a side effect. A bank-select bit in the line control register swaps the data and enable offsets for the two halves of a 16-bit divisor.

Top module: `uart_regfile`

## Requirements
- R1: After a synchronous reset, line status reads 0x60, the identification register reads 0xC1, irq is low, and line control, modem control, enable, scratch and both divisor bytes read 0x00.
- R2: With line control bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte; with it clear, offset 0 is the data port and offset 1 the enable register. Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read.
- R3: The enable register stores only bits 3:0 of a write, and a read returns those bits with bits 7:4 zero. Bit 0 enables the receive/timeout source, bit 1 the transmit-empty source, bit 3 the modem-status source.
- R4: The identification code is 0xC when the timeout source is pending and enabled; otherwise 0x2 when the transmit-empty source is pending and enabled; otherwise 0x1. `irq` is high exactly when the code is not 0x1.
- R5: A read of offset 2 returns 0xC0 OR the code. If that code is 0x2, the read clears the transmit-empty pending bit.
- R6: A data-port write with bank select clear sets the transmit-empty pending bit and, in the next cycle, pulses `tx_valid` with the byte on `tx_byte`, except that 0xFF is never forwarded although the pending bit is still set.
- R7: Each `rx_valid` cycle pushes `rx_byte` into a 16-entry queue, sets line status bit 0 and sets the timeout pending bit. A push into a full queue is discarded.
- R8: A data-port read returns the oldest queued byte and removes it; when the queue becomes empty, line status bit 0 and the timeout pending bit clear. A data-port read of an empty queue returns 0x00 and changes nothing.
- R9: Offsets 3, 4 and 7 are plain read/write bytes. Writes to offsets 5 and 6 have no effect, and offset 6 reads 0x00.
- R10: A write to offset 2 with bit 1 set empties the receive queue and clears data ready and the timeout pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle pulse for an outgoing byte |
| tx_byte | output | 8 | Outgoing byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is both sources pending and enabled at once, then watching the code fall from timeout to transmit-empty as the queue drains, and finally clearing transmit-empty only through an identification read that sees code 0x2. Directed sequences build this ordering exactly, and a long seeded random mix of pushes, register writes (including bank-select flips, partial enables and flushes) and reads of every offset revisits it under varied queue depths, with a bench model predicting every read, the interrupt line and the transmit stream.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  typedef enum logic [3:0] {
    IID_MSR  = 4'h0,
    IID_NONE = 4'h1,
    IID_THR  = 4'h2,
    IID_RDA  = 4'h4,
    IID_RLS  = 4'h6,
    IID_TMO  = 4'hC
  } iid_e;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_IID  = 3'd2;
  localparam logic [2:0] OFS_LCTL = 3'd3;
  localparam logic [2:0] OFS_MCTL = 3'd4;
  localparam logic [2:0] OFS_LSTA = 3'd5;
  localparam logic [2:0] OFS_MSTA = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam int BANK_BIT  = 7;
  localparam int FLUSH_BIT = 1;
endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        push,
  input  logic [DW-1:0]               push_data,
  input  logic                        pop,
  output logic [DW-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        empty,
  output logic                        last
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign last    = (count == CW'(1));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !flush) |=> (count == '0));

  // R7
  push_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |=> (count != '0));
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_rf_pkg::*;
(
  input  logic tmo_pend,
  input  logic thr_pend,
  input  logic msr_pend,
  input  logic en_rx,
  input  logic en_tx,
  input  logic en_ms,
  output iid_e code,
  output logic req
);
  always_comb begin
    if (tmo_pend && en_rx)      code = IID_TMO;
    else if (thr_pend && en_tx) code = IID_THR;
    else if (msr_pend && en_ms) code = IID_MSR;
    else                        code = IID_NONE;
  end

  assign req = (code != IID_NONE);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int RXQ_DEPTH = 16,
  parameter int DW        = 8,
  parameter int DIV_W     = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  output logic          irq
);
  localparam int CW = $clog2(RXQ_DEPTH+1);
  localparam int EN_W = 4;

  logic [DIV_W-1:0] divisor;
  logic [EN_W-1:0]  ien;
  logic [DW-1:0]    lctl, mctl, scr;
  logic             tmo_pend, thr_pend;
  logic             bank;
  logic [DW-1:0]    q_head;
  logic [CW-1:0]    q_count;
  logic             q_empty, q_last;
  logic             q_pop, q_flush;
  logic             data_wr;
  logic [DW-1:0]    lsta;
  iid_e             code;
  logic             req;

  assign bank    = lctl[BANK_BIT];
  assign q_pop   = bus_rd && (bus_addr == OFS_DATA) && !bank;
  assign data_wr = bus_wr && (bus_addr == OFS_DATA) && !bank;
  assign q_flush = bus_wr && (bus_addr == OFS_IID) && bus_wdata[FLUSH_BIT];
  assign lsta    = {1'b0, 1'b1, 1'b1, 4'b0000, !q_empty};

  uart_rx_queue #(.DEPTH(RXQ_DEPTH), .DW(DW)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .flush     (q_flush),
    .push      (rx_valid),
    .push_data (rx_byte),
    .pop       (q_pop),
    .head      (q_head),
    .count     (q_count),
    .empty     (q_empty),
    .last      (q_last)
  );

  uart_irq_prio u_prio (
    .tmo_pend (tmo_pend),
    .thr_pend (thr_pend),
    .msr_pend (1'b0),
    .en_rx    (ien[0]),
    .en_tx    (ien[1]),
    .en_ms    (ien[3]),
    .code     (code),
    .req      (req)
  );

  assign irq = req;

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      divisor <= '0;
      ien     <= '0;
      lctl    <= '0;
      mctl    <= '0;
      scr     <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DATA: if (bank) divisor[7:0]  <= bus_wdata;
        OFS_IEN:  if (bank) divisor[15:8] <= bus_wdata;
                  else      ien           <= bus_wdata[EN_W-1:0];
        OFS_LCTL: lctl <= bus_wdata;
        OFS_MCTL: mctl <= bus_wdata;
        OFS_SCR:  scr  <= bus_wdata;
        default:  ;
      endcase
    end
  end

  // pending sources
  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_pend <= 1'b0;
      thr_pend <= 1'b0;
    end else begin
      if (rx_valid)
        tmo_pend <= 1'b1;
      else if (q_flush || (q_pop && q_last))
        tmo_pend <= 1'b0;
      if (data_wr)
        thr_pend <= 1'b1;
      else if (bus_rd && (bus_addr == OFS_IID) && (code == IID_THR))
        thr_pend <= 1'b0;
    end
  end

  // transmit stream
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= data_wr && (bus_wdata != 8'hFF);
      if (data_wr && (bus_wdata != 8'hFF)) tx_byte <= bus_wdata;
    end
  end

  // registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_DATA: bus_rdata <= bank ? divisor[7:0]  : q_head;
        OFS_IEN:  bus_rdata <= bank ? divisor[15:8] : {4'b0000, ien};
        OFS_IID:  bus_rdata <= {2'b11, 2'b00, code};
        OFS_LCTL: bus_rdata <= lctl;
        OFS_MCTL: bus_rdata <= mctl;
        OFS_LSTA: bus_rdata <= lsta;
        OFS_MSTA: bus_rdata <= 8'h00;
        default:  bus_rdata <= scr;
      endcase
    end
  end

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((tmo_pend && ien[0]) || (thr_pend && ien[1])));

  // R5
  iid_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == OFS_IID) && (code == IID_THR)) |=> !thr_pend);

  // R6
  tx_no_ff_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_byte != 8'hFF));

  // R6
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> thr_pend);

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (q_pop && q_last && !rx_valid) |=> (!tmo_pend && q_empty));

  // strobes are exclusive
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
endmodule

// File: tb/test_uart_regfile.sv
module test_uart_regfile;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       irq;

  always #2 clk = ~clk;

  uart_regfile i_uart_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_q [16];
  int          m_n, m_rp, m_wp;
  logic [15:0] m_div;
  logic [3:0]  m_ien;
  logic [7:0]  m_lctl, m_mctl, m_scr;
  bit          m_tmo, m_thr;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] m_code();
    if (m_tmo && m_ien[0]) return 4'hC;
    if (m_thr && m_ien[1]) return 4'h2;
    return 4'h1;
  endfunction

  task automatic model_reset();
    m_n = 0; m_rp = 0; m_wp = 0; m_div = 0; m_ien = 0;
    m_lctl = 0; m_mctl = 0; m_scr = 0; m_tmo = 0; m_thr = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(posedge clk); #1;
    if (m_n < 16) begin m_q[m_wp] = b; m_wp = (m_wp + 1) % 16; m_n++; end
    m_tmo = 1;
    @(negedge clk); rx_valid = 0;
    check("R4 irq", irq, m_code() != 4'h1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bit bank;
    bank = m_lctl[7];
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    case (a)
      3'd0: if (bank) m_div[7:0] = d; else m_thr = 1;
      3'd1: if (bank) m_div[15:8] = d; else m_ien = d[3:0];
      3'd2: if (d[1]) begin m_n = 0; m_rp = 0; m_wp = 0; m_tmo = 0; end
      3'd3: m_lctl = d;
      3'd4: m_mctl = d;
      3'd7: m_scr = d;
      default: ;
    endcase
    if (a == 3'd0 && !bank) begin
      check("R6 tx_valid", tx_valid, d != 8'hFF);
      if (d != 8'hFF) check("R6 tx_byte", tx_byte, d);
    end else check("R6 tx idle", tx_valid, 0);
    @(negedge clk); bus_wr = 0;
    check("R4 irq", irq, m_code() != 4'h1);
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    logic [7:0] e;
    bit bank;
    bank = m_lctl[7];
    case (a)
      3'd0: if (bank) e = m_div[7:0];
            else if (m_n == 0) e = 8'h00;
            else e = m_q[m_rp];
      3'd1: e = bank ? m_div[15:8] : {4'h0, m_ien};
      3'd2: e = {4'hC, m_code()};
      3'd3: e = m_lctl;
      3'd4: e = m_mctl;
      3'd5: e = {7'b0110000, m_n != 0};
      3'd6: e = 8'h00;
      default: e = m_scr;
    endcase
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(posedge clk); #1;
    check(req, bus_rdata, e);
    if (a == 3'd0 && !bank && m_n > 0) begin
      m_rp = (m_rp + 1) % 16; m_n--;
      if (m_n == 0) m_tmo = 0;
    end
    if (a == 3'd2 && e[3:0] == 4'h2) m_thr = 0;
    @(negedge clk); bus_rd = 0;
    check("R4 irq", irq, m_code() != 4'h1);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);
    rst = 1; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_byte = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    check("R1 irq", irq, 0);
    rd(3'd5, "R1 lsta");
    rd(3'd2, "R1 iid");
    rd(3'd3, "R1 lctl");
    rd(3'd4, "R1 mctl");
    rd(3'd1, "R1 ien");
    rd(3'd7, "R1 scr");
    wr(3'd3, 8'h80);
    rd(3'd0, "R1 div lo");
    rd(3'd1, "R1 div hi");

    // R2 bank overlay
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd(3'd0, "R2 div lo"); rd(3'd1, "R2 div hi");
    check("R2 no thr", irq, 0);
    wr(3'd3, 8'h03);
    rd(3'd1, "R2 ien view");

    // R3 enable width
    wr(3'd1, 8'hFA);
    rd(3'd1, "R3 ien low bits");
    wr(3'd1, 8'h00);

    // R6 transmit and 0xFF drop, R5 identification clear
    wr(3'd0, 8'h41);
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h02);
    check("R4 thr irq", irq, 1);
    rd(3'd2, "R5 iid thr");
    rd(3'd2, "R5 iid after clear");
    check("R5 irq low", irq, 0);

    // R7 fill past depth, R4 priority
    wr(3'd0, 8'h55);
    wr(3'd1, 8'h03);
    for (int i = 0; i < 17; i++) push(8'(8'hA0 + i));
    rd(3'd5, "R7 data ready");
    rd(3'd2, "R4 timeout wins");
    for (int i = 0; i < 16; i++) rd(3'd0, "R8 pop order");
    rd(3'd5, "R8 ready cleared");
    rd(3'd2, "R4 thr after drain");
    rd(3'd0, "R8 empty read");
    rd(3'd5, "R8 empty unchanged");

    // R9 storage and ignored offsets
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
    rd(3'd5, "R9 lsta ignored"); rd(3'd6, "R9 msta zero");
    wr(3'd4, 8'h1B); wr(3'd7, 8'hC3);
    rd(3'd4, "R9 mctl"); rd(3'd7, "R9 scr");

    // R10 flush
    push(8'h11); push(8'h22);
    wr(3'd2, 8'h02);
    rd(3'd5, "R10 flushed");
    rd(3'd0, "R10 empty data");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [2:0] a;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      a  = 3'($urandom_range(0, 7));
      d  = 8'($urandom);
      if (a == 3'd3 && $urandom_range(0, 3) != 0) d[7] = 0;
      if (a == 3'd2 && $urandom_range(0, 3) != 0) d[1] = 0;
      if (op < 3) push(d);
      else if (op < 6) wr(a, d);
      else rd(a, "R2 R3 R4 R5 R8 R9 random read");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule